// File: doc/BRIEF.md
# Watchdog Timer with Selectable Tick and Expiry Action

This block is a countdown watchdog for a system controller. Software programs a 16-bit reload value, starts the timer and must keep writing a reload trigger before the count runs out. If it does not, the block marks the timer as fired and issues a one-cycle request to the system: either a reset or an orderly shutdown, chosen by a control bit. A separate configuration byte, kept in the always-on power domain, chooses one of four tick periods and holds a global disable. A sticky cause flag in that same domain records that the watchdog requested a reset, so firmware can read it after the reset has happened.

There are two register words on a simple write-enable bus: a control word at byte offset 0 and a reload-value word at byte offset 4. Reads are combinational from the address. The configuration byte has its own write strobe and read port. Two resets come in: `por` clears the always-on byte and the cause flag, while `rst` clears only the timer registers.

Top module: `wdt_timer`

## Requirements
- R1: After `por` and `rst`, the control word reads 0x08, the reload word reads 0, the configuration byte reads 0x01 and neither request output is high.
- R2: While configuration bit 0 (global disable) is 1, control bit 3 reads 1 and a write that sets control bit 0 (run) leaves run at 0 and produces no request.
- R3: Control bits 6:4 and bit 7 (reload trigger) always read 0; reload-word bits 31:16 are dropped on write and read 0; other offsets read 0.
- R4: Configuration bits 2:1 set the tick to 32 us (00), 10 ms (01), 100 ms (10) or 1 s (11) of the reference clock; a write with run and reload set, with reload value N, produces its request max(N,1) ticks after that write's clock edge.
- R5: On expiry with control bit 2 at 0, `sys_reset_req` pulses for exactly one cycle and control bit 1 (fired) reads 1.
- R6: With control bit 2 at 1, expiry pulses `sys_shutdown_req` instead, never both, and the cause flag stays 0.
- R7: Fired stays set until a control write with bit 1 at 1 clears it; a write with bit 1 at 0 leaves it set.
- R8: Writing the reload trigger reloads the counter and restarts the tick phase, so a trigger written before expiry delays the request to a full period after it.
- R9: After expiry the counter holds at zero and no further request is issued until a reload trigger or a fresh start.
- R10: Clearing run pauses both counter and tick phase without a request; setting run again without a reload continues from the held count with a fresh tick phase.
- R11: Configuration bit 7 (cause) is set by a watchdog reset request, is read-only, survives `rst` and is cleared only by `por`.
- R12: Setting the global disable while running stops the timer at once with no request; clearing it leaves the timer stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| por | input | 1 | Power-on reset, synchronous, clears always-on byte and cause |
| rst | input | 1 | System reset, synchronous, clears timer registers |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Byte offset: 0 control, 4 reload value |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_wdata | input | 8 | Configuration write data (bits 2:0 used) |
| cfg_rdata | output | 8 | Configuration byte with cause in bit 7 |
| sys_reset_req | output | 1 | One-cycle reset request on expiry |
| sys_shutdown_req | output | 1 | One-cycle shutdown request on expiry |
| wd_caused_reset | output | 1 | Sticky cause flag |

## Verification
A wrong tick length or a prescaler that is not restarted shows up as a request arriving a few cycles early or late, so every expiry is timed to the exact cycle from the starting write. A counter that fails to hold at zero, or an arm flag that is not cleared, shows as a second request within one tick period of the first, which the idle windows after each expiry catch. Faults in the sticky bits show at the next register read after the offending write or reset, since the bench reads the control word and configuration byte straight after each such event.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        RES_32US  = 2'd0,
        RES_10MS  = 2'd1,
        RES_100MS = 2'd2,
        RES_1S    = 2'd3
    } tick_res_e;

    // Timer state held in the system-reset domain.
    typedef struct packed {
        logic run;
        logic fired;
        logic shdn_sel;
    } ctrl_t;

    // Always-on configuration; packed so res lands on byte bits 2:1.
    typedef struct packed {
        tick_res_e res;
        logic      gdis;
    } cfg_t;

    localparam logic [2:0] OFS_CTRL  = 3'd0;
    localparam logic [2:0] OFS_COUNT = 3'd4;

    localparam int unsigned BIT_RUN    = 0;
    localparam int unsigned BIT_FIRED  = 1;
    localparam int unsigned BIT_SHDN   = 2;
    localparam int unsigned BIT_RELOAD = 7;

    localparam cfg_t CFG_POR = '{res: RES_32US, gdis: 1'b1};

    function automatic longint unsigned res_period_us(tick_res_e r);
        case (r)
            RES_32US:  return 64'd32;
            RES_10MS:  return 64'd10000;
            RES_100MS: return 64'd100000;
            default:   return 64'd1000000;
        endcase
    endfunction

    // Reference-clock cycles per tick, at least one.
    function automatic int unsigned res_tick_len(tick_res_e r, int unsigned khz);
        longint unsigned c;
        c = res_period_us(r) * 64'(khz) / 64'd1000;
        if (c == 64'd0) c = 64'd1;
        return 32'(c);
    endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
    import wdt_pkg::*;
#(
    parameter int unsigned REF_CLK_KHZ = 48000,
    parameter int unsigned PRE_W       = 26
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      run,
    input  logic      restart,
    input  tick_res_e res,
    output logic      tick
);

    localparam int unsigned NUM_RES = 4;

    logic [PRE_W-1:0] last_tab [NUM_RES];
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] last;

    for (genvar g = 0; g < NUM_RES; g++) begin : g_len
        assign last_tab[g] = PRE_W'(res_tick_len(tick_res_e'(2'(g)), REF_CLK_KHZ) - 1);
    end

    assign last = last_tab[res];
    // >= so that a resolution change mid-period cannot overrun
    assign tick = run && !restart && (pre_q >= last);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
        end else if (restart) begin
            pre_q <= '0;
        end else if (run) begin
            if (pre_q >= last) pre_q <= '0;
            else               pre_q <= pre_q + 1'b1;
        end
    end

    p_restart_phase_r8: assert property (@(posedge clk) disable iff (rst)
        restart |=> (pre_q == '0));

    p_pause_phase_r10: assert property (@(posedge clk) disable iff (rst)
        (!run && !restart) |=> $stable(pre_q));

endmodule

// File: rtl/wdt_downcount.sv
module wdt_downcount #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             arm,
    output logic             expire
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             armed_q;

    // Last tick of the period: count at one (or already zero) and armed.
    assign expire = run && tick && armed_q && !load && (cnt_q <= ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else begin
            if (load)                            cnt_q <= load_val;
            else if (run && tick && cnt_q != '0) cnt_q <= cnt_q - ONE;

            if (load || arm)  armed_q <= 1'b1;
            else if (expire)  armed_q <= 1'b0;
        end
    end

    p_hold_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '0 && !load) |=> (cnt_q == '0));

    p_single_fire_r9: assert property (@(posedge clk) disable iff (rst)
        expire |=> !expire);

    p_no_tick_stopped_r10: assert property (@(posedge clk) disable iff (rst)
        (!run && !load) |=> $stable(cnt_q));

endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             por,
    input  logic             rst,
    input  logic             bus_we,
    input  logic [2:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic             cfg_we,
    input  logic [7:0]       cfg_wdata,
    output logic [7:0]       cfg_rdata,
    input  logic             expire,
    output logic             run,
    output logic             fired,
    output logic             shdn_sel,
    output tick_res_e        res,
    output logic             reload,
    output logic             run_rise,
    output logic [CNT_W-1:0] load_val,
    output logic             cause
);

    ctrl_t            ctrl_q;
    cfg_t             cfg_q;
    cfg_t             cfg_nxt;
    logic [CNT_W-1:0] rld_q;
    logic             cause_q;
    logic             wr_ctrl;
    logic             wr_cnt;
    logic             unused_wdata;

    assign unused_wdata = ^{bus_wdata[31:CNT_W], cfg_wdata[7:3]};

    assign wr_ctrl = bus_we && (bus_addr == OFS_CTRL);
    assign wr_cnt  = bus_we && (bus_addr == OFS_COUNT);
    assign cfg_nxt = cfg_we ? cfg_t'(cfg_wdata[2:0]) : cfg_q;

    assign reload   = wr_ctrl && bus_wdata[BIT_RELOAD];
    assign run_rise = wr_ctrl && bus_wdata[BIT_RUN] && !ctrl_q.run && !cfg_nxt.gdis;

    // Always-on domain: only power-on reset clears it.
    always_ff @(posedge clk) begin
        if (por) begin
            cfg_q   <= CFG_POR;
            cause_q <= 1'b0;
        end else begin
            cfg_q <= cfg_nxt;
            if (expire && !ctrl_q.shdn_sel) cause_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            rld_q  <= '0;
        end else begin
            ctrl_q.run <= (wr_ctrl ? bus_wdata[BIT_RUN] : ctrl_q.run) && !cfg_nxt.gdis;
            if (wr_ctrl) ctrl_q.shdn_sel <= bus_wdata[BIT_SHDN];
            if (expire)                             ctrl_q.fired <= 1'b1;
            else if (wr_ctrl && bus_wdata[BIT_FIRED]) ctrl_q.fired <= 1'b0;
            if (wr_cnt) rld_q <= bus_wdata[CNT_W-1:0];
        end
    end

    always_comb begin
        case (bus_addr)
            OFS_CTRL:  bus_rdata = {24'd0, 4'd0, cfg_q.gdis, ctrl_q.shdn_sel,
                                   ctrl_q.fired, ctrl_q.run};
            OFS_COUNT: bus_rdata = {{(32-CNT_W){1'b0}}, rld_q};
            default:   bus_rdata = '0;
        endcase
    end

    assign cfg_rdata = {cause_q, 4'd0, cfg_q};
    assign run       = ctrl_q.run;
    assign fired     = ctrl_q.fired;
    assign shdn_sel  = ctrl_q.shdn_sel;
    assign res       = cfg_q.res;
    assign load_val  = rld_q;
    assign cause     = cause_q;

    p_dis_blocks_run_r2: assert property (@(posedge clk) disable iff (rst || por)
        cfg_q.gdis |-> !ctrl_q.run);

    p_fired_w1c_r7: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.fired && !(wr_ctrl && bus_wdata[BIT_FIRED])) |=> ctrl_q.fired);

    p_cause_sticky_r11: assert property (@(posedge clk) disable iff (por)
        cause_q |=> cause_q);

endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
    import wdt_pkg::*;
#(
    parameter int unsigned REF_CLK_KHZ = 48000,
    parameter int unsigned CNT_W       = 16
) (
    input  logic        clk,
    input  logic        por,
    input  logic        rst,
    input  logic        bus_we,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        cfg_we,
    input  logic [7:0]  cfg_wdata,
    output logic [7:0]  cfg_rdata,
    output logic        sys_reset_req,
    output logic        sys_shutdown_req,
    output logic        wd_caused_reset
);

    localparam int unsigned MAX_TICK = res_tick_len(RES_1S, REF_CLK_KHZ);
    localparam int unsigned PRE_W    = $clog2(MAX_TICK + 1);

    logic             run;
    logic             fired;
    logic             shdn_sel;
    tick_res_e        res;
    logic             reload;
    logic             run_rise;
    logic [CNT_W-1:0] load_val;
    logic             tick;
    logic             expire;
    logic             rst_req_q;
    logic             shdn_req_q;

    wdt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .por       (por),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .expire    (expire),
        .run       (run),
        .fired     (fired),
        .shdn_sel  (shdn_sel),
        .res       (res),
        .reload    (reload),
        .run_rise  (run_rise),
        .load_val  (load_val),
        .cause     (wd_caused_reset)
    );

    wdt_prescaler #(.REF_CLK_KHZ(REF_CLK_KHZ), .PRE_W(PRE_W)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .restart (reload || run_rise),
        .res     (res),
        .tick    (tick)
    );

    wdt_downcount #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .tick     (tick),
        .load     (reload),
        .load_val (load_val),
        .arm      (run_rise),
        .expire   (expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_req_q  <= 1'b0;
            shdn_req_q <= 1'b0;
        end else begin
            rst_req_q  <= expire && !shdn_sel;
            shdn_req_q <= expire && shdn_sel;
        end
    end

    assign sys_reset_req    = rst_req_q;
    assign sys_shutdown_req = shdn_req_q;

    p_req_excl_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rst_req_q, shdn_req_q}));

    p_req_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        (rst_req_q || shdn_req_q) |=> !(rst_req_q || shdn_req_q));

    p_req_fired_r5: assert property (@(posedge clk) disable iff (rst)
        (rst_req_q || shdn_req_q) |-> fired);

    p_cause_follows_r11: assert property (@(posedge clk) disable iff (rst || por)
        rst_req_q |-> wd_caused_reset);

endmodule

// File: tb/wdt_timer_bench.sv
module wdt_timer_bench;

    // 250 kHz nominal reference: ticks of 8, 2500, 25000, 250000 cycles.
    localparam int unsigned KHZ = 250;
    localparam int NVEC = 6;
    // res, reload value, shutdown select, expected cycles to request
    localparam int VEC [NVEC][4] = '{
        '{0, 1, 1, 8},
        '{0, 3, 1, 24},
        '{0, 0, 0, 8},
        '{0, 5, 0, 40},
        '{1, 2, 0, 5000},
        '{2, 1, 0, 25000}
    };

    logic        clk = 1'b0;
    logic        por = 1'b1;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        sys_reset_req;
    logic        sys_shutdown_req;
    logic        wd_caused_reset;

    int checks = 0;
    int errors = 0;
    int n_rst  = 0;
    int n_shdn = 0;
    int n_wide = 0;
    logic prev_req = 1'b0;
    bit done = 0;

    always #2.5 clk = ~clk;

    wdt_timer #(.REF_CLK_KHZ(KHZ)) u_wdt_timer (
        .clk              (clk),
        .por              (por),
        .rst              (rst),
        .bus_we           (bus_we),
        .bus_addr         (bus_addr),
        .bus_wdata        (bus_wdata),
        .bus_rdata        (bus_rdata),
        .cfg_we           (cfg_we),
        .cfg_wdata        (cfg_wdata),
        .cfg_rdata        (cfg_rdata),
        .sys_reset_req    (sys_reset_req),
        .sys_shutdown_req (sys_shutdown_req),
        .wd_caused_reset  (wd_caused_reset)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (sys_reset_req)    n_rst++;
            if (sys_shutdown_req) n_shdn++;
            if (prev_req && (sys_reset_req || sys_shutdown_req)) n_wide++;
        end
        prev_req <= sys_reset_req || sys_shutdown_req;
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic cfg_write(logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic bus_read(logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic wait_req(int limit, output int n);
        n = 0;
        while (!(sys_reset_req || sys_shutdown_req) && n < limit) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int n;
        int base_r;
        int base_s;

        repeat (3) @(negedge clk);
        por = 1'b0; rst = 1'b0;
        @(negedge clk);

        // R1: reset values
        bus_read(3'd0, rd); chk("R1 ctrl", rd, 32'h08);
        bus_read(3'd4, rd); chk("R1 count", rd, 32'h0);
        chk("R1 cfg", {24'd0, cfg_rdata}, 32'h01);
        chk("R1 req", {30'd0, sys_reset_req, sys_shutdown_req}, 32'h0);

        // R2: run ignored while globally disabled
        bus_write(3'd4, 32'd1);
        bus_write(3'd0, 32'h81);
        repeat (50) @(negedge clk);
        bus_read(3'd0, rd); chk("R2 ctrl", rd, 32'h08);
        chk("R2 no req", n_rst + n_shdn, 0);

        // R3: reserved and high bits
        cfg_write(8'h00);
        bus_write(3'd4, 32'hFFFF_FFFF);
        bus_read(3'd4, rd); chk("R3 count upper", rd, 32'h0000_FFFF);
        bus_write(3'd0, 32'hF4);
        bus_read(3'd0, rd); chk("R3 ctrl rsvd", rd, 32'h04);
        bus_read(3'd2, rd); chk("R3 other ofs", rd, 32'h0);
        bus_write(3'd0, 32'h00);

        // Table of expiries: R4 timing, R5/R6 request line, fired
        for (int i = 0; i < NVEC; i++) begin
            base_r = n_rst; base_s = n_shdn;
            cfg_write(8'(VEC[i][0] << 1));
            bus_write(3'd4, 32'(VEC[i][1]));
            bus_write(3'd0, 32'h02);
            bus_write(3'd0, 32'h81 | 32'(VEC[i][2] << 2));
            wait_req(VEC[i][3] + 20, n);
            chk("R4 expiry cycles", n, VEC[i][3]);
            chk(VEC[i][2] != 0 ? "R6 shutdown line" : "R5 reset line",
                {30'd0, sys_reset_req, sys_shutdown_req},
                VEC[i][2] != 0 ? 32'h1 : 32'h2);
            @(negedge clk);
            chk("R5 one-cycle pulse", {30'd0, sys_reset_req, sys_shutdown_req}, 32'h0);
            bus_read(3'd0, rd);
            chk("R5 fired set", rd, 32'h03 | 32'(VEC[i][2] << 2));
            chk("R6 pulse count", (n_rst - base_r) + (n_shdn - base_s), 1);
            if (i == 1) chk("R6 cause untouched", {31'd0, cfg_rdata[7]}, 32'h0);
            if (i == 2) chk("R11 cause set", {31'd0, cfg_rdata[7]}, 32'h1);
            bus_write(3'd0, 32'h02);
        end
        chk("R5 no wide pulse", n_wide, 0);

        // R8: kick before expiry
        cfg_write(8'h00);
        bus_write(3'd4, 32'd4);
        base_r = n_rst;
        bus_write(3'd0, 32'h81);
        repeat (19) @(negedge clk);
        bus_write(3'd0, 32'h81);
        chk("R8 no early req", n_rst - base_r, 0);
        wait_req(60, n);
        chk("R8 delayed expiry", n, 32);

        // R9: holds at zero, no second request
        repeat (100) @(negedge clk);
        chk("R9 single request", n_rst - base_r, 1);

        // R7: fired write-one-to-clear
        bus_write(3'd0, 32'h01);
        bus_read(3'd0, rd); chk("R7 fired kept", rd, 32'h03);
        bus_write(3'd0, 32'h00);
        bus_read(3'd0, rd); chk("R7 fired kept stop", rd, 32'h02);
        bus_write(3'd0, 32'h02);
        bus_read(3'd0, rd); chk("R7 fired cleared", rd, 32'h00);

        // R10: pause and resume without reload
        bus_write(3'd4, 32'd2);
        base_r = n_rst;
        bus_write(3'd0, 32'h81);
        repeat (5) @(negedge clk);
        bus_write(3'd0, 32'h00);
        repeat (100) @(negedge clk);
        chk("R10 paused no req", n_rst - base_r, 0);
        bus_write(3'd0, 32'h01);
        wait_req(60, n);
        chk("R10 resume cycles", n, 16);
        bus_write(3'd0, 32'h02);

        // R12: global disable while running
        bus_write(3'd4, 32'd3);
        base_r = n_rst;
        bus_write(3'd0, 32'h81);
        repeat (3) @(negedge clk);
        cfg_write(8'h01);
        bus_read(3'd0, rd); chk("R12 stopped", rd, 32'h08);
        repeat (100) @(negedge clk);
        chk("R12 no req", n_rst - base_r, 0);
        cfg_write(8'h00);
        bus_read(3'd0, rd); chk("R12 stays stopped", rd, 32'h00);

        // R4: 1 s tick does not fire early
        cfg_write(8'h06);
        bus_write(3'd4, 32'd1);
        bus_write(3'd0, 32'h81);
        repeat (2000) @(negedge clk);
        chk("R4 long tick quiet", n_rst - base_r, 0);
        bus_write(3'd0, 32'h02);

        // R11: cause survives system reset, cleared by power-on reset
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 cause kept", {24'd0, cfg_rdata}, 32'h86);
        bus_read(3'd0, rd); chk("R11 ctrl reset", rd, 32'h00);
        bus_read(3'd4, rd); chk("R11 count reset", rd, 32'h00);
        por = 1'b1; rst = 1'b1;
        repeat (2) @(negedge clk);
        por = 1'b0; rst = 1'b0;
        @(negedge clk);
        chk("R11 cause cleared", {24'd0, cfg_rdata}, 32'h01);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule